// File: doc/BRIEF.md
# Compare-Match Up Counter

The block is a timer that counts upward at a fixed fraction of its clock. One compare register sets the period: when the count meets it, the count returns to zero and a period flag is raised. A second compare register acts as an alarm that raises its own flag without disturbing the count. Software drives the timer through eight word registers on a single-cycle read and write port. It issues commands (restart, halt, snapshot), sets and clears interrupt enables, clears flags, and reads a count snapshot plus a status word. The interrupt line is high whenever a flag is pending and its enable is set.

Writes to the command, period and alarm registers do not take effect at once. They are staged and applied a fixed number of cycles later, and a status bit shows the pending window. The count cannot be read directly. A snapshot command copies it into a readable register, and that register keeps its value until the next snapshot. The period compare looks for equality only. If the period is lowered below the running count, the match is missed until the count rolls over past its all-ones value.

Top module: `tt_timer`

## Requirements
- R1: After reset the count and snapshot are 0, the timer is stopped, the period register (index 5) is all ones, the alarm register (index 6) is 0, enables and flags are 0, the status word (index 7) is 0 and `irq` is low.
- R2: A write to index 0 (command), 5 (period) or 6 (alarm) sets status bit 0 (busy) during the SYNC_CYCLES cycles that follow the write edge. The written value takes effect on the edge where busy drops. A write to any of these three indices while busy is high is discarded.
- R3: Command bit 0 (restart) clears the count and prescaler phase and starts counting, also when the timer is already running. Status bit 1 then reads 1.
- R4: Command bit 1 (halt) stops counting and clears the count to 0, and status bit 1 reads 0. Halt wins if both bits are set.
- R5: While running, the count advances by exactly one every 2^PRESC_LOG2 clock cycles.
- R6: On an advance step where the count equals the period register, the count becomes 0 and flag bit 0 is set.
- R7: The period match is equality only. After the period is lowered below the count, the count keeps rising through all ones, wraps to 0, and matches the new period on the next pass.
- R8: On an advance step where the count equals the alarm register, flag bit 1 is set and the count is not reset.
- R9: Writing 1 to a bit of index 3 clears that flag. Writing 0 has no effect. A flag being set in the same cycle as its clear stays set.
- R10: Writing 1 to a bit of index 1 sets that enable and writing 1 to a bit of index 2 clears it; zero bits leave enables alone. Both indices read back the enables. `irq` is high exactly when some flag is set and enabled.
- R11: Command bit 2 (snapshot) copies the count into index 4 when it takes effect. Index 4 holds that value until the next snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index for read and write |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq | output | 1 | OR of enabled pending flags |

## Verification
Two things can land on the same clock edge: an advance step that sets a flag, and a software write that clears that flag. The bench makes the period zero, so every advance step matches, and it times a restart so the advance edges are known exactly. It then places one clear write on an advance edge and one on the edge between. The flag must still read 1 after the first write, read 0 after the second, and be set again at the next advance. A matching alarm and period on the same step is also covered by the assertions that relate the hit strobes to the flag register.

// File: rtl/tt_pkg.sv
package tt_pkg;

   typedef enum logic [2:0] {
      RA_CMD     = 3'd0,
      RA_IEN_SET = 3'd1,
      RA_IEN_CLR = 3'd2,
      RA_FLAGS   = 3'd3,
      RA_COUNT   = 3'd4,
      RA_TOP     = 3'd5,
      RA_ALARM   = 3'd6,
      RA_STATUS  = 3'd7
   } reg_addr_e;

   typedef enum logic [1:0] {
      SK_CMD   = 2'd0,
      SK_TOP   = 2'd1,
      SK_ALARM = 2'd2
   } sync_kind_e;

   localparam int unsigned CMD_RESTART = 0;
   localparam int unsigned CMD_HALT    = 1;
   localparam int unsigned CMD_SNAP    = 2;

   localparam int unsigned FLG_TOP   = 0;
   localparam int unsigned FLG_ALARM = 1;
   localparam int unsigned N_FLAGS   = 2;

   localparam int unsigned ST_BUSY = 0;
   localparam int unsigned ST_RUN  = 1;

endpackage

// File: rtl/tt_sync_ctrl.sv
module tt_sync_ctrl
   import tt_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  sync_kind_e        req_kind,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              apply,
   output sync_kind_e        app_kind,
   output logic [DATA_W-1:0] app_data
);

   localparam int unsigned CW = $clog2(SYNC_CYCLES + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q   <= '0;
         app_kind <= SK_CMD;
         app_data <= '0;
      end else if (req_valid && (left_q == '0)) begin
         left_q   <= CW'(SYNC_CYCLES);
         app_kind <= req_kind;
         app_data <= req_data;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy  = (left_q != '0);
   assign apply = (left_q == CW'(1));

   assert_busy_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy |=> busy);

   assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && busy |=> $stable(app_data));

   assert_apply_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> !busy);

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int unsigned DIV_LOG2 = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic phase_clr,
   output logic tick
);

   generate
      if (DIV_LOG2 == 0) begin : g_direct
         assign tick = run;
      end else begin : g_div
         logic [DIV_LOG2-1:0] ph_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ph_q <= '0;
            end else if (phase_clr) begin
               ph_q <= '0;
            end else if (run) begin
               ph_q <= ph_q + 1'b1;
            end
         end

         assign tick = run && (&ph_q);

         assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/tt_core.sv
module tt_core
   import tt_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             apply,
   input  sync_kind_e       app_kind,
   input  logic [CNT_W-1:0] app_data,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] top_q,
   output logic [CNT_W-1:0] alarm_q,
   output logic [CNT_W-1:0] snap_q,
   output logic             running_q,
   output logic             cmd_zero,
   output logic             top_hit,
   output logic             alarm_hit
);

   logic cmd_apply;
   logic do_halt;
   logic do_restart;

   assign cmd_apply  = apply && (app_kind == SK_CMD);
   assign do_halt    = cmd_apply && app_data[CMD_HALT];
   assign do_restart = cmd_apply && app_data[CMD_RESTART] && !app_data[CMD_HALT];
   assign cmd_zero   = do_halt || do_restart;

   assign top_hit   = tick && (count_q == top_q);
   assign alarm_hit = tick && (count_q == alarm_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q   <= '0;
         running_q <= 1'b0;
      end else if (do_halt) begin
         count_q   <= '0;
         running_q <= 1'b0;
      end else if (do_restart) begin
         count_q   <= '0;
         running_q <= 1'b1;
      end else if (tick) begin
         count_q <= top_hit ? '0 : count_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q   <= '1;
         alarm_q <= '0;
         snap_q  <= '0;
      end else begin
         if (apply && (app_kind == SK_TOP))   top_q   <= app_data;
         if (apply && (app_kind == SK_ALARM)) alarm_q <= app_data;
         if (cmd_apply && app_data[CMD_SNAP]) snap_q  <= count_q;
      end
   end

   assert_wrap_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !cmd_zero && (count_q == top_q) |=> count_q == '0);

   assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !cmd_zero && (count_q != top_q) |=> count_q == $past(count_q) + 1'b1);

   assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !cmd_zero |=> $stable(count_q));

   assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !running_q |-> count_q == '0);

endmodule

// File: rtl/tt_timer.sv
module tt_timer
   import tt_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned PRESC_LOG2  = 1,
   parameter int unsigned SYNC_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq
);

   if (CNT_W < 8) begin : g_bad_width
      $error("tt_timer: CNT_W must be at least 8");
   end
   if (SYNC_CYCLES < 1) begin : g_bad_sync
      $error("tt_timer: SYNC_CYCLES must be at least 1");
   end
   if (PRESC_LOG2 > 15) begin : g_bad_presc
      $error("tt_timer: PRESC_LOG2 must be below 16");
   end

   reg_addr_e ra;
   assign ra = reg_addr_e'(addr);

   logic             sync_req;
   sync_kind_e       sync_kind;
   logic             busy;
   logic             apply;
   sync_kind_e       app_kind;
   logic [CNT_W-1:0] app_data;

   always_comb begin
      sync_req  = 1'b0;
      sync_kind = SK_CMD;
      if (wr_en) begin
         case (ra)
            RA_CMD:   begin sync_req = 1'b1; sync_kind = SK_CMD;   end
            RA_TOP:   begin sync_req = 1'b1; sync_kind = SK_TOP;   end
            RA_ALARM: begin sync_req = 1'b1; sync_kind = SK_ALARM; end
            default:  ;
         endcase
      end
   end

   tt_sync_ctrl #(.DATA_W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (sync_req),
      .req_kind  (sync_kind),
      .req_data  (wdata),
      .busy      (busy),
      .apply     (apply),
      .app_kind  (app_kind),
      .app_data  (app_data)
   );

   logic             tick;
   logic             running;
   logic             cmd_zero;
   logic             top_hit;
   logic             alarm_hit;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] top_q;
   logic [CNT_W-1:0] alarm_q;
   logic [CNT_W-1:0] snap_q;

   tt_prescaler #(.DIV_LOG2(PRESC_LOG2)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (running),
      .phase_clr (cmd_zero),
      .tick      (tick)
   );

   tt_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .apply     (apply),
      .app_kind  (app_kind),
      .app_data  (app_data),
      .count_q   (count_q),
      .top_q     (top_q),
      .alarm_q   (alarm_q),
      .snap_q    (snap_q),
      .running_q (running),
      .cmd_zero  (cmd_zero),
      .top_hit   (top_hit),
      .alarm_hit (alarm_hit)
   );

   logic [N_FLAGS-1:0] ien_q;
   logic [N_FLAGS-1:0] flags_q;
   logic [N_FLAGS-1:0] flag_set;
   logic [N_FLAGS-1:0] flag_clr;

   always_comb begin
      flag_set            = '0;
      flag_set[FLG_TOP]   = top_hit;
      flag_set[FLG_ALARM] = alarm_hit;
      flag_clr            = (wr_en && (ra == RA_FLAGS)) ? wdata[N_FLAGS-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q   <= '0;
         flags_q <= '0;
      end else begin
         flags_q <= (flags_q & ~flag_clr) | flag_set;
         if (wr_en && (ra == RA_IEN_SET)) ien_q <= ien_q | wdata[N_FLAGS-1:0];
         if (wr_en && (ra == RA_IEN_CLR)) ien_q <= ien_q & ~wdata[N_FLAGS-1:0];
      end
   end

   assign irq = |(flags_q & ien_q);

   always_comb begin
      rdata = '0;
      case (ra)
         RA_IEN_SET, RA_IEN_CLR: rdata = CNT_W'(ien_q);
         RA_FLAGS:  rdata = CNT_W'(flags_q);
         RA_COUNT:  rdata = snap_q;
         RA_TOP:    rdata = top_q;
         RA_ALARM:  rdata = alarm_q;
         RA_STATUS: begin
            rdata[ST_BUSY] = busy;
            rdata[ST_RUN]  = running;
         end
         default:   rdata = '0;
      endcase
   end

   assert_top_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      top_hit |=> flags_q[FLG_TOP]);

   assert_alarm_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> flags_q[FLG_ALARM]);

   assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (ra == RA_FLAGS) && wdata[FLG_TOP] && !top_hit |=> !flags_q[FLG_TOP]);

   assert_ien_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (ra == RA_IEN_SET) && wdata[FLG_TOP] |=> ien_q[FLG_TOP]);

endmodule

// File: tb/tt_timer_bench.sv
`timescale 1ns/100ps
module tt_timer_bench;
   import tt_pkg::*;

   localparam int unsigned W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   addr = 3'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq;

   always #2 clk = ~clk;

   tt_timer #(.CNT_W(W), .PRESC_LOG2(1), .SYNC_CYCLES(2)) u_tt_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .irq   (irq)
   );

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  ev_item;
   int    n_chk = 0;
   int    n_err = 0;

   // monitor: pops expected items and compares with the design's outputs
   initial begin
      item_t       it;
      logic [31:0] act;
      forever begin
         @(ev_item);
         while (q.size() > 0) begin
            it  = q.pop_front();
            act = (it.sel == 8) ? {31'd0, irq} : {20'd0, rdata};
            n_chk++;
            if (act !== it.exp) begin
               n_err++;
               $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_item(input int sel, input logic [31:0] exp, input string tag);
      item_t it;
      if (sel < 8) addr = sel[2:0];
      #0.2;
      it.sel = sel; it.exp = exp; it.tag = tag;
      q.push_back(it);
      -> ev_item;
      #0.2;
   endtask

   task automatic check_le(input logic [31:0] act, input logic [31:0] lim, input string tag);
      n_chk++;
      if (act > lim) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected<=%0h", tag, act, lim);
      end
   endtask

   task automatic check_gt(input logic [31:0] act, input logic [31:0] lim, input string tag);
      n_chk++;
      if (act <= lim) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected>%0h", tag, act, lim);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input reg_addr_e a, input logic [W-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic snap(output logic [W-1:0] v);
      wr(RA_CMD, W'(1 << CMD_SNAP));
      wait_cyc(2);
      addr = RA_COUNT;
      #0.2;
      v = rdata;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [W-1:0] v1;
      logic [W-1:0] v2;
      logic [W-1:0] v3;

      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      expect_item(RA_COUNT, 0, "R1 count");
      expect_item(RA_TOP, 32'hFFF, "R1 period");
      expect_item(8, 0, "R1 irq");
      wait_cyc(1);
      expect_item(RA_STATUS, 0, "R1 status");
      expect_item(RA_IEN_SET, 0, "R1 enables");
      expect_item(RA_FLAGS, 0, "R1 flags");
      wait_cyc(1);
      expect_item(RA_ALARM, 0, "R1 alarm");

      // R2 staged write, busy window, write during busy dropped
      wr(RA_ALARM, 12'd77);
      expect_item(RA_STATUS, 1, "R2 busy after write");
      expect_item(RA_ALARM, 0, "R2 alarm not yet applied");
      wr(RA_TOP, 12'd9);
      expect_item(RA_STATUS, 1, "R2 busy second cycle");
      wait_cyc(1);
      expect_item(RA_STATUS, 0, "R2 busy dropped");
      expect_item(RA_ALARM, 77, "R2 alarm applied");
      expect_item(RA_TOP, 32'hFFF, "R2 write during busy dropped");

      // R3 restart from stopped
      wr(RA_CMD, W'(1 << CMD_RESTART));
      wait_cyc(2);
      wr(RA_CMD, W'(1 << CMD_SNAP));
      wait_cyc(2);
      expect_item(RA_COUNT, 1, "R3 count after restart");
      expect_item(RA_STATUS, 2, "R3 running");

      // R5 rate and R11 snapshot hold
      snap(v1);
      wait_cyc(97);
      snap(v2);
      expect_item(RA_COUNT, 32'(v1) + 50, "R5 advance over 100 cycles");
      wait_cyc(40);
      expect_item(RA_COUNT, 32'(v1) + 50, "R11 snapshot holds");

      // R3 restart while running
      wr(RA_CMD, W'(1 << CMD_RESTART));
      wait_cyc(2);
      wr(RA_CMD, W'(1 << CMD_SNAP));
      wait_cyc(2);
      expect_item(RA_COUNT, 1, "R3 restart while running");

      // R4 halt clears and stops
      wr(RA_CMD, W'(1 << CMD_HALT));
      wait_cyc(2);
      expect_item(RA_STATUS, 0, "R4 stopped");
      snap(v1);
      expect_item(RA_COUNT, 0, "R4 count zero");
      wait_cyc(20);
      snap(v1);
      expect_item(RA_COUNT, 0, "R4 count stays zero");

      // R6 / R8 wrap and alarm timing
      wr(RA_TOP, 12'd5);   wait_cyc(2);
      wr(RA_ALARM, 12'd3); wait_cyc(2);
      wr(RA_FLAGS, 12'd3);
      wr(RA_CMD, W'(1 << CMD_RESTART));
      wait_cyc(9);
      expect_item(RA_FLAGS, 0, "R8 before alarm step");
      wait_cyc(1);
      expect_item(RA_FLAGS, 2, "R8 alarm flag");
      wait_cyc(3);
      expect_item(RA_FLAGS, 2, "R6 before period step");
      wait_cyc(1);
      expect_item(RA_FLAGS, 3, "R6 period flag");

      // R10 enables and irq
      expect_item(8, 0, "R10 irq masked");
      wr(RA_IEN_SET, 12'd1);
      expect_item(8, 1, "R10 irq on period flag");
      wr(RA_IEN_CLR, 12'd2);
      expect_item(RA_IEN_SET, 1, "R10 zero bit untouched");
      expect_item(8, 1, "R10 irq still on");
      wr(RA_IEN_CLR, 12'd1);
      expect_item(8, 0, "R10 irq off");
      expect_item(RA_IEN_CLR, 0, "R10 enables clear");
      wr(RA_IEN_SET, 12'd2);
      expect_item(8, 1, "R10 irq on alarm flag");
      wr(RA_IEN_CLR, 12'd2);

      snap(v3);
      check_le(32'(v3), 5, "R6 count stays within period");

      // R9 clear colliding with set
      wr(RA_CMD, W'(1 << CMD_HALT)); wait_cyc(2);
      wr(RA_TOP, 12'd0);             wait_cyc(2);
      wr(RA_ALARM, 12'h800);         wait_cyc(2);
      wr(RA_FLAGS, 12'd3);
      wr(RA_CMD, W'(1 << CMD_RESTART));
      wait_cyc(3);
      wr(RA_FLAGS, 12'd1);
      expect_item(RA_FLAGS, 1, "R9 set wins over clear");
      wr(RA_FLAGS, 12'd1);
      expect_item(RA_FLAGS, 0, "R9 clear between steps");
      wait_cyc(1);
      expect_item(RA_FLAGS, 1, "R9 set again next step");

      // R7 period lowered below count
      wr(RA_TOP, 12'hFFF);
      wait_cyc(2);
      wr(RA_CMD, W'(1 << CMD_RESTART));
      wait_cyc(2);
      wait_cyc(60);
      wr(RA_FLAGS, 12'd3);
      wr(RA_TOP, 12'd3);
      wait_cyc(2);
      snap(v1);
      check_gt(32'(v1), 3, "R7 count above new period");
      wait_cyc(100);
      expect_item(RA_FLAGS, 0, "R7 no match when passed");
      snap(v2);
      check_gt(32'(v2), 32'(v1), "R7 count keeps rising");
      wait_cyc(8400);
      expect_item(RA_FLAGS, 3, "R7 match after rollover");
      snap(v3);
      check_le(32'(v3), 3, "R7 count within new period");

      wait_cyc(2);
      summary();
      $finish;
   end

endmodule